// File: doc/BRIEF.md
# Sixteen-Bit Capture and Reload Timer

This block is a 16-bit timer/counter with a byte-wide special-function-register port for a small processor core. The processor reads and writes six byte registers: the two count bytes, the two reload/capture bytes, a control register and a mode register. Once started, the counter advances on either an internal tick enable or on falling edges of an external count pin. When it overflows it either reloads from the reload/capture registers or wraps to zero.

A second external pin, the trigger, acts on its falling edge. Depending on the mode, that edge either copies the running count into the capture registers or forces a reload. When up/down counting is enabled, the trigger's level instead sets the count direction. An overflow can also toggle a wave output pin. It can stand in for another timer's overflow as the serial receive or transmit baud tick. A single interrupt request combines the overflow flag and the external-event flag.

Top module: `tmr16_capreload`

## Requirements
- R1: After reset every register reads 00h, and `irq`, `wave_out` and `rx_baud_tick` are 0 (with `t1_ovf_in` = 0).
- R2: The register map is fixed. The count is at CCh (low) and CDh (high). The reload/capture value is at CAh (low) and CBh (high). Control is at C8h, with bits 7 down to 0 being: overflow flag, external flag, rx baud select, tx baud select, external-trigger enable, run, external count source, capture mode. Mode is at C9h, with bit 1 as wave-output enable and bit 0 as up/down enable; its bits 7:2 read 0. Any other address reads 00h and ignores writes.
- R3: With run = 1 and external count source = 0, the count increments by one on each clock where `tick_in` = 1. With run = 0 it holds.
- R4: With the external count source selected, `tick_in` is ignored. Each falling edge of `cnt_pin` is passed through a two-flop synchronizer and advances the count. The count has changed after the third rising clock edge following the pin's fall, and not after the second.
- R5: When capture mode = 0 and the count is FFFFh, a count step loads the reload value and sets the overflow flag.
- R6: When capture mode = 1, an overflow wraps the count to 0000h and sets the overflow flag. With trigger enable = 1, a falling edge of `trig_pin` copies the current count into the reload/capture registers, sets the external flag, and does not stop counting.
- R7: When capture mode = 0 and trigger enable = 1, a falling edge of `trig_pin` loads the count from the reload registers and sets the external flag. With trigger enable = 0 the edge has no effect.
- R8: Both flags stay set until the processor writes the control register. Writing 1 to a flag sets it. `irq` = overflow flag OR (external flag AND NOT up/down enable).
- R9: When up/down enable = 1 and capture mode = 0, the synchronized level of `trig_pin` selects the direction: 1 counts up, 0 counts down. Counting down from a count equal to the reload value wraps to FFFFh and sets the overflow flag. Counting up overflows as in R5. Trigger edges load nothing and set no flag.
- R10: While either baud select bit is 1, overflows do not set the overflow flag and always reload (also in capture mode), and trigger edges do not load or capture. A selected baud tick output is high for the one clock cycle after the overflow edge. An unselected baud tick output follows `t1_ovf_in`.
- R11: With wave-output enable = 1, each overflow or underflow inverts `wave_out` at the same clock edge.
- R12: A processor write to a count byte takes precedence over a count step in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sfr_addr | input | 8 | Register address |
| sfr_wr | input | 1 | Register write strobe |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data (combinational from `sfr_addr`) |
| tick_in | input | 1 | Internal count enable |
| cnt_pin | input | 1 | External count pin (asynchronous) |
| trig_pin | input | 1 | Trigger / direction pin (asynchronous) |
| t1_ovf_in | input | 1 | Other timer's overflow pulse |
| wave_out | output | 1 | Toggling wave output |
| rx_baud_tick | output | 1 | Serial receive baud tick |
| tx_baud_tick | output | 1 | Serial transmit baud tick |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a trigger edge that lands while the counter is running. It is also the case most sensitive to timing, because the capture must take the value from before the step, three clocks after the pin moves. The bench starts counting and drops the trigger in the same cycle, then checks both the captured value and the count that kept advancing. The down-count wrap is reached in a similar way: the trigger pin is held low long enough to pass the synchronizer before any tick arrives, so the step that meets the reload value is a down step.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

  typedef struct packed {
    logic ovf_flag;
    logic ext_flag;
    logic rx_sel;
    logic tx_sel;
    logic ext_en;
    logic run;
    logic src_ext;
    logic cap_mode;
  } ctrl_t;

  typedef struct packed {
    logic wave_en;
    logic updown_en;
  } mode_t;

endpackage

// File: rtl/tmr16_pin_sync.sv
module tmr16_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level,
  output logic fall
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], pin};
  end

  assign level = sh[STAGES-1];
  assign fall  = sh[STAGES] & ~sh[STAGES-1];

  // R4: a recognized edge lasts exactly one cycle
  assert_fall_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/tmr16_core.sv
module tmr16_core #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [CNT_W/DATA_W-1:0]     cnt_wr,
  input  logic [CNT_W/DATA_W-1:0]     rld_wr,
  input  logic [DATA_W-1:0]           wdata,
  input  logic                        step_en,
  input  logic                        count_down,
  input  logic                        trig_load,
  input  logic                        trig_capture,
  input  logic                        reload_on_wrap,
  output logic [CNT_W-1:0]            cnt_q,
  output logic [CNT_W-1:0]            rld_q,
  output logic                        wrap_evt
);
  localparam int BYTES = CNT_W / DATA_W;
  localparam logic [CNT_W-1:0] TOP = '1;

  function automatic logic at_limit(input logic [CNT_W-1:0] c,
                                    input logic [CNT_W-1:0] r,
                                    input logic down);
    return down ? (c == r) : (c == TOP);
  endfunction

  function automatic logic [CNT_W-1:0] next_val(input logic [CNT_W-1:0] c,
                                                input logic [CNT_W-1:0] r,
                                                input logic down,
                                                input logic reload);
    if (at_limit(c, r, down)) return down ? TOP : (reload ? r : '0);
    return down ? c - 1'b1 : c + 1'b1;
  endfunction

  logic             step_go;
  logic [CNT_W-1:0] cnt_nxt, rld_nxt;

  assign step_go  = step_en & ~(|cnt_wr) & ~trig_load;
  assign wrap_evt = step_go & at_limit(cnt_q, rld_q, count_down);

  always_comb begin
    cnt_nxt = cnt_q;
    if (trig_load)    cnt_nxt = rld_q;
    else if (step_go) cnt_nxt = next_val(cnt_q, rld_q, count_down, reload_on_wrap);
    for (int b = 0; b < BYTES; b++)
      if (cnt_wr[b]) cnt_nxt[b*DATA_W +: DATA_W] = wdata;
  end

  always_comb begin
    rld_nxt = rld_q;
    if (trig_capture) rld_nxt = cnt_q;
    for (int b = 0; b < BYTES; b++)
      if (rld_wr[b]) rld_nxt[b*DATA_W +: DATA_W] = wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rld_q <= '0;
    end else begin
      cnt_q <= cnt_nxt;
      rld_q <= rld_nxt;
    end
  end

  assert_reload_on_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && !count_down && reload_on_wrap) |=> cnt_q == $past(rld_q));

  assert_underflow_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && count_down) |=> cnt_q == TOP);

  assert_capture_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_capture && rld_wr == '0) |=> rld_q == $past(cnt_q));

  assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_en && cnt_wr == '0 && !trig_load) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr16_ctrl.sv
module tmr16_ctrl
  import tmr16_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic              mode_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wrap_evt,
  input  logic              ext_evt,
  input  logic              t1_ovf_in,
  output ctrl_t             ctrl_q,
  output mode_t             mode_q,
  output logic              irq,
  output logic              wave_out,
  output logic              rx_baud_tick,
  output logic              tx_baud_tick
);
  ctrl_t ctrl_nxt;
  logic  baud, wrap_q;

  assign baud = ctrl_q.rx_sel | ctrl_q.tx_sel;

  always_comb begin
    ctrl_nxt = ctrl_q;
    if (ctrl_wr) ctrl_nxt = ctrl_t'(wdata[7:0]);
    if (wrap_evt && !baud) ctrl_nxt.ovf_flag = 1'b1;
    if (ext_evt)           ctrl_nxt.ext_flag = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      mode_q   <= '0;
      wrap_q   <= 1'b0;
      wave_out <= 1'b0;
    end else begin
      ctrl_q <= ctrl_nxt;
      if (mode_wr) mode_q <= mode_t'(wdata[1:0]);
      wrap_q <= wrap_evt;
      if (wrap_evt && mode_q.wave_en) wave_out <= ~wave_out;
    end
  end

  assign rx_baud_tick = ctrl_q.rx_sel ? wrap_q : t1_ovf_in;
  assign tx_baud_tick = ctrl_q.tx_sel ? wrap_q : t1_ovf_in;
  assign irq = ctrl_q.ovf_flag | (ctrl_q.ext_flag & ~mode_q.updown_en);

  assert_flag_on_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && !baud) |=> ctrl_q.ovf_flag);

  assert_no_flag_in_baud_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && baud && !ctrl_wr && !ctrl_q.ovf_flag) |=> !ctrl_q.ovf_flag);

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_wr && ctrl_q.ovf_flag && ctrl_q.ext_flag) |=> (ctrl_q.ovf_flag && ctrl_q.ext_flag));

  assert_toggle_out_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && mode_q.wave_en) |=> wave_out != $past(wave_out));
endmodule

// File: rtl/tmr16_capreload.sv
module tmr16_capreload
  import tmr16_pkg::*;
#(
  parameter int          CNT_W       = 16,
  parameter int          DATA_W      = 8,
  parameter int          SYNC_STAGES = 2,
  parameter logic [7:0]  A_CTRL      = 8'hC8,
  parameter logic [7:0]  A_MODE      = 8'hC9,
  parameter logic [7:0]  A_RLD_LO    = 8'hCA,
  parameter logic [7:0]  A_RLD_HI    = 8'hCB,
  parameter logic [7:0]  A_CNT_LO    = 8'hCC,
  parameter logic [7:0]  A_CNT_HI    = 8'hCD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        sfr_addr,
  input  logic              sfr_wr,
  input  logic [DATA_W-1:0] sfr_wdata,
  output logic [DATA_W-1:0] sfr_rdata,
  input  logic              tick_in,
  input  logic              cnt_pin,
  input  logic              trig_pin,
  input  logic              t1_ovf_in,
  output logic              wave_out,
  output logic              rx_baud_tick,
  output logic              tx_baud_tick,
  output logic              irq
);
  localparam int BYTES = CNT_W / DATA_W;

  ctrl_t            ctrl_q;
  mode_t            mode_q;
  logic [CNT_W-1:0] cnt_q, rld_q;
  logic             cnt_level, cnt_fall, trig_level, trig_fall;
  logic             updown, baud, step_en, count_down;
  logic             trig_qual, trig_load, trig_capture, reload_on_wrap;
  logic             wrap_evt;
  logic [BYTES-1:0] cnt_wr, rld_wr;
  logic             ctrl_wr, mode_wr;

  assign cnt_wr  = {sfr_wr && sfr_addr == A_CNT_HI, sfr_wr && sfr_addr == A_CNT_LO};
  assign rld_wr  = {sfr_wr && sfr_addr == A_RLD_HI, sfr_wr && sfr_addr == A_RLD_LO};
  assign ctrl_wr = sfr_wr && sfr_addr == A_CTRL;
  assign mode_wr = sfr_wr && sfr_addr == A_MODE;

  tmr16_pin_sync #(.STAGES(SYNC_STAGES)) u_cnt_sync (
    .clk(clk), .rst_n(rst_n), .pin(cnt_pin), .level(cnt_level), .fall(cnt_fall));

  tmr16_pin_sync #(.STAGES(SYNC_STAGES)) u_trig_sync (
    .clk(clk), .rst_n(rst_n), .pin(trig_pin), .level(trig_level), .fall(trig_fall));

  assign updown         = mode_q.updown_en & ~ctrl_q.cap_mode;
  assign baud           = ctrl_q.rx_sel | ctrl_q.tx_sel;
  assign step_en        = ctrl_q.run & (ctrl_q.src_ext ? cnt_fall : tick_in);
  assign count_down     = updown & ~trig_level;
  assign trig_qual      = ctrl_q.ext_en & trig_fall & ~updown;
  assign trig_load      = trig_qual & ~ctrl_q.cap_mode & ~baud;
  assign trig_capture   = trig_qual & ctrl_q.cap_mode & ~baud;
  assign reload_on_wrap = ~ctrl_q.cap_mode | baud;

  tmr16_core #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_core (
    .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .rld_wr(rld_wr), .wdata(sfr_wdata),
    .step_en(step_en), .count_down(count_down), .trig_load(trig_load),
    .trig_capture(trig_capture), .reload_on_wrap(reload_on_wrap),
    .cnt_q(cnt_q), .rld_q(rld_q), .wrap_evt(wrap_evt));

  tmr16_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .mode_wr(mode_wr), .wdata(sfr_wdata),
    .wrap_evt(wrap_evt), .ext_evt(trig_qual), .t1_ovf_in(t1_ovf_in),
    .ctrl_q(ctrl_q), .mode_q(mode_q), .irq(irq), .wave_out(wave_out),
    .rx_baud_tick(rx_baud_tick), .tx_baud_tick(tx_baud_tick));

  always_comb begin
    case (sfr_addr)
      A_CNT_LO: sfr_rdata = cnt_q[DATA_W-1:0];
      A_CNT_HI: sfr_rdata = cnt_q[CNT_W-1:DATA_W];
      A_RLD_LO: sfr_rdata = rld_q[DATA_W-1:0];
      A_RLD_HI: sfr_rdata = rld_q[CNT_W-1:DATA_W];
      A_CTRL:   sfr_rdata = ctrl_q;
      A_MODE:   sfr_rdata = {{(DATA_W-2){1'b0}}, mode_q};
      default:  sfr_rdata = '0;
    endcase
  end

  // R7: with trigger enable low, no trigger edge may move the count
  assert_trig_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.ext_en && !ctrl_q.run && cnt_wr == '0) |=> $stable(cnt_q));

  // R4: count source select keeps tick_in away when counting pin edges
  assert_ext_ignores_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.src_ext && !cnt_fall && !trig_qual && cnt_wr == '0) |=> $stable(cnt_q));

  logic unused_ok;
  assign unused_ok = cnt_level;
endmodule

// File: tb/tmr16_capreload_tb.sv
module tmr16_capreload_tb_top;
  localparam int CLK_P = 10;

  localparam logic [7:0] A_CTRL = 8'hC8, A_MODE = 8'hC9, A_RLO = 8'hCA,
                         A_RHI = 8'hCB, A_CLO = 8'hCC, A_CHI = 8'hCD;

  // {reload[57:42], start[41:26], ticks[25:18], cap_mode[17], exp_cnt[16:1], exp_flag[0]}
  localparam int NV = 5;
  localparam logic [57:0] VEC [NV] = '{
    {16'h0000, 16'h0010, 8'd5, 1'b0, 16'h0015, 1'b0},
    {16'h1234, 16'hFFFE, 8'd3, 1'b0, 16'h1235, 1'b1},
    {16'h1234, 16'hFFFF, 8'd2, 1'b1, 16'h0001, 1'b1},
    {16'hABCD, 16'hFFFD, 8'd3, 1'b0, 16'hABCD, 1'b1},
    {16'h0000, 16'h00FF, 8'd1, 1'b0, 16'h0100, 1'b0}
  };

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [7:0] sfr_addr = 8'h00, sfr_wdata = 8'h00, sfr_rdata;
  logic       sfr_wr = 1'b0, tick_in = 1'b0, cnt_pin = 1'b1, trig_pin = 1'b1, t1_ovf_in = 1'b0;
  logic       wave_out, rx_baud_tick, tx_baud_tick, irq;
  int         n_chk = 0, n_err = 0;
  bit         done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  tmr16_capreload dut_i (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .tick_in(tick_in),
    .cnt_pin(cnt_pin), .trig_pin(trig_pin), .t1_ovf_in(t1_ovf_in),
    .wave_out(wave_out), .rx_baud_tick(rx_baud_tick), .tx_baud_tick(tx_baud_tick),
    .irq(irq));

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
    step(1);
    sfr_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    sfr_addr = a;
    #1;
    d = sfr_rdata;
  endtask

  task automatic rd16(input logic [7:0] a_lo, input logic [7:0] a_hi, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(a_lo, lo);
    rd(a_hi, hi);
    v = {hi, lo};
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set16(input logic [7:0] a_lo, input logic [7:0] a_hi, input logic [15:0] v);
    wr(a_lo, v[7:0]);
    wr(a_hi, v[15:8]);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] v;
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    rd(A_CTRL, b); chk("R1 ctrl", b, 8'h00);
    rd(A_MODE, b); chk("R1 mode", b, 8'h00);
    rd16(A_CLO, A_CHI, v); chk("R1 count", v, 16'h0000);
    rd16(A_RLO, A_RHI, v); chk("R1 reload", v, 16'h0000);
    chk("R1 irq", irq, 1'b0);
    chk("R1 wave_out", wave_out, 1'b0);
    chk("R1 rx tick", rx_baud_tick, 1'b0);

    // R2 map and unused bits
    wr(A_MODE, 8'hFF); rd(A_MODE, b); chk("R2 mode unused bits", b, 8'h03);
    wr(A_MODE, 8'h00);
    wr(8'h55, 8'hAA); rd(8'h55, b); chk("R2 unmapped read", b, 8'h00);
    rd16(A_CLO, A_CHI, v); chk("R2 unmapped write ignored", v, 16'h0000);
    wr(A_CTRL, 8'h1B); rd(A_CTRL, b); chk("R2 ctrl readback", b, 8'h1B);
    wr(A_CTRL, 8'h00);

    // R3/R5/R6 vector table
    for (int i = 0; i < NV; i++) begin
      wr(A_CTRL, 8'h00);
      set16(A_RLO, A_RHI, VEC[i][57:42]);
      set16(A_CLO, A_CHI, VEC[i][41:26]);
      wr(A_CTRL, {5'b00000, 1'b1, 1'b0, VEC[i][17]});
      tick_in = 1'b1;
      step(int'(VEC[i][25:18]));
      tick_in = 1'b0;
      rd16(A_CLO, A_CHI, v);
      chk($sformatf("R3/R5/R6 vector %0d count", i), v, VEC[i][16:1]);
      rd(A_CTRL, b);
      chk($sformatf("R5/R6 vector %0d overflow flag", i), b[7], VEC[i][0]);
    end

    // R3 hold when stopped
    wr(A_CTRL, 8'h00);
    set16(A_CLO, A_CHI, 16'h0033);
    tick_in = 1'b1; step(5); tick_in = 1'b0;
    rd16(A_CLO, A_CHI, v); chk("R3 hold while stopped", v, 16'h0033);

    // R4 external count pin, timing through synchronizer
    wr(A_CTRL, 8'h06);
    tick_in = 1'b1;
    cnt_pin = 1'b0;
    step(2);
    rd16(A_CLO, A_CHI, v); chk("R4 no change after two edges", v, 16'h0033);
    step(1);
    rd16(A_CLO, A_CHI, v); chk("R4 advanced after third edge", v, 16'h0034);
    tick_in = 1'b0; cnt_pin = 1'b1; step(3);
    rd16(A_CLO, A_CHI, v); chk("R4 rising edge ignored", v, 16'h0034);

    // R7 reload on trigger, gated then enabled
    wr(A_CTRL, 8'h00);
    set16(A_RLO, A_RHI, 16'h2222);
    set16(A_CLO, A_CHI, 16'h0005);
    trig_pin = 1'b0; step(4);
    rd16(A_CLO, A_CHI, v); chk("R7 gated edge no load", v, 16'h0005);
    rd(A_CTRL, b); chk("R7 gated edge no flag", b, 8'h00);
    trig_pin = 1'b1; step(3);
    wr(A_CTRL, 8'h08);
    trig_pin = 1'b0; step(3);
    rd16(A_CLO, A_CHI, v); chk("R7 trigger reload", v, 16'h2222);
    rd(A_CTRL, b); chk("R7 external flag", b, 8'h48);
    chk("R8 irq from external flag", irq, 1'b1);
    trig_pin = 1'b1; step(3);

    // R6 capture while counting
    wr(A_CTRL, 8'h00);
    set16(A_CLO, A_CHI, 16'h0000);
    set16(A_RLO, A_RHI, 16'h0000);
    wr(A_CTRL, 8'h0D);
    tick_in = 1'b1; trig_pin = 1'b0;
    step(3);
    tick_in = 1'b0;
    rd16(A_RLO, A_RHI, v); chk("R6 captured pre-step count", v, 16'h0002);
    rd16(A_CLO, A_CHI, v); chk("R6 count kept running", v, 16'h0003);
    rd(A_CTRL, b); chk("R6 external flag on capture", b[6], 1'b1);
    trig_pin = 1'b1; step(3);

    // R8 flags
    wr(A_CTRL, 8'h00); rd(A_CTRL, b); chk("R8 cleared by write", b, 8'h00);
    chk("R8 irq low", irq, 1'b0);
    wr(A_CTRL, 8'h80); chk("R8 irq from overflow flag written", irq, 1'b1);
    step(3); rd(A_CTRL, b); chk("R8 flag stays set", b, 8'h80);
    wr(A_CTRL, 8'h00);

    // R9 up/down counting
    wr(A_MODE, 8'h01);
    set16(A_RLO, A_RHI, 16'h0010);
    set16(A_CLO, A_CHI, 16'h0012);
    trig_pin = 1'b0; step(3);
    wr(A_CTRL, 8'h04);
    tick_in = 1'b1; step(3); tick_in = 1'b0;
    rd16(A_CLO, A_CHI, v); chk("R9 down underflow wraps", v, 16'hFFFF);
    rd(A_CTRL, b); chk("R9 overflow flag on underflow", b[7], 1'b1);
    trig_pin = 1'b1; step(3);
    tick_in = 1'b1; step(1); tick_in = 1'b0;
    rd16(A_CLO, A_CHI, v); chk("R9 up overflow reloads", v, 16'h0010);
    wr(A_CTRL, 8'h40);
    chk("R8/R9 external flag masked in up/down", irq, 1'b0);
    wr(A_MODE, 8'h00);
    chk("R8 external flag unmasked", irq, 1'b1);
    wr(A_MODE, 8'h01);
    wr(A_CTRL, 8'h08);
    set16(A_CLO, A_CHI, 16'h0077);
    trig_pin = 1'b0; step(4);
    rd16(A_CLO, A_CHI, v); chk("R9 trigger edge loads nothing", v, 16'h0077);
    rd(A_CTRL, b); chk("R9 trigger edge sets no flag", b, 8'h08);
    trig_pin = 1'b1; step(3);
    wr(A_MODE, 8'h00);

    // R10 baud source
    wr(A_CTRL, 8'h00);
    set16(A_RLO, A_RHI, 16'h8000);
    set16(A_CLO, A_CHI, 16'hFFFF);
    wr(A_CTRL, 8'h24);
    tick_in = 1'b1; step(1); tick_in = 1'b0;
    chk("R10 rx tick pulse", rx_baud_tick, 1'b1);
    t1_ovf_in = 1'b1; #1;
    chk("R10 tx follows other timer", tx_baud_tick, 1'b1);
    t1_ovf_in = 1'b0;
    rd16(A_CLO, A_CHI, v); chk("R10 reload in baud mode", v, 16'h8000);
    rd(A_CTRL, b); chk("R10 no overflow flag", b[7], 1'b0);
    step(1); chk("R10 rx tick one cycle", rx_baud_tick, 1'b0);
    wr(A_CTRL, 8'h00);
    set16(A_CLO, A_CHI, 16'hFFFF);
    wr(A_CTRL, 8'h25);
    tick_in = 1'b1; step(1); tick_in = 1'b0;
    rd16(A_CLO, A_CHI, v); chk("R10 capture mode still reloads", v, 16'h8000);

    // R11 wave output
    wr(A_CTRL, 8'h00);
    wr(A_MODE, 8'h02);
    set16(A_CLO, A_CHI, 16'hFFFF);
    wr(A_CTRL, 8'h04);
    tick_in = 1'b1; step(1); tick_in = 1'b0;
    chk("R11 wave toggles high", wave_out, 1'b1);
    set16(A_CLO, A_CHI, 16'hFFFF);
    tick_in = 1'b1; step(1); tick_in = 1'b0;
    chk("R11 wave toggles low", wave_out, 1'b0);
    wr(A_MODE, 8'h00);

    // R12 write priority
    set16(A_CLO, A_CHI, 16'h0000);
    tick_in = 1'b1;
    wr(A_CLO, 8'h50);
    tick_in = 1'b0;
    rd16(A_CLO, A_CHI, v); chk("R12 write beats step", v, 16'h0050);

    finish_run();
  end
endmodule